// File: doc/BRIEF.md
# Byte-to-Word Packing DMA Engine

This block carries the data phase of a disk transfer between an 8-bit byte handshake stream on the controller side and a 16-bit system bus on the memory side. When the transfer runs toward memory, it collects two bytes into one word before it asks for the bus. When it runs from memory, it fetches a word and hands it out as two bytes. As a result, each bus cycle carries two bytes.

A sequencer starts the engine with a start pulse once a command has been fully sent and needs data. The start pulse samples the direction flag. The sequencer ends the engine with a stop pulse. The memory address is a 23-bit word address, which is the byte address shifted right by one. Software loads it while the engine is idle and can read it back. The address advances by one after each acknowledged word when the increment enable is set.

The engine requests mastership on one configurable level out of six. It accepts the grant on that level and holds a grant-acknowledge line until its word cycle ends. A grant that arrives while the engine neither requests nor owns the bus passes down the daisy chain. A word cycle that gets no data acknowledge within the timeout window is ended. In that case a sticky non-existent-memory flag is set and the transfer halts. Only the interface reset clears the flag.

Top module: `dma_pack_engine`

## Requirements
- R1: In to-memory direction (dir_to_mem=1 at start) the first byte accepted goes to bus_wdata[15:8] and the second to bus_wdata[7:0]. Exactly one write cycle (bus_we=1) is made per two bytes.
- R2: In from-memory direction (dir_to_mem=0 at start) each word read on an acknowledged cycle (bus_we=0) is presented on out_byte as bits 15:8 first, then bits 7:0.
- R3: The 23-bit word address is loaded from addr_wval by addr_load only while busy=0. A load while busy=1 has no effect. addr_q reads the register back, and bus_addr carries the same value.
- R4: After each acknowledged cycle the address grows by one (wrapping from 7FFFFF to 0) when inc_en=1. When inc_en=0 it is unchanged.
- R5: The engine asks for the bus only on bit LVL (default 3) of the 6-bit bus_req vector. It starts a cycle only after bg_in[LVL] is seen with its request up.
- R6: bus_gack and bus_strobe rise on the cycle after the grant is accepted. They stay high until the cycle in which bus_dtack is seen, and are low on the following cycle.
- R7: bg_in[LVL] is copied to bg_out[LVL] while no request is pending and no cycle is owned, and is blocked otherwise. The other grant levels always pass straight through.
- R8: A word cycle that sees no bus_dtack for 64 clock cycles ends after exactly 64 strobe cycles. It then sets nxm_err, and the engine returns to idle.
- R9: nxm_err stays set until an if_reset pulse. A start pulse while nxm_err=1 is ignored.
- R10: A start pulse while idle begins a transfer (busy=1) in the direction sampled from dir_to_mem on that edge.
- R11: A stop pulse outside a bus cycle returns the engine to idle at once and drops any half-filled byte pair. A stop pulse during a bus cycle lets that cycle finish first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Start pulse from the sequencer |
| xfer_stop | input | 1 | Stop pulse from the sequencer |
| dir_to_mem | input | 1 | 1: controller bytes to memory, 0: memory to controller |
| if_reset | input | 1 | Interface reset: idles the engine and clears nxm_err |
| addr_load | input | 1 | Load strobe for the word address |
| addr_wval | input | 23 | Word address to load |
| inc_en | input | 1 | Address increment enable |
| addr_q | output | 23 | Current word address |
| busy | output | 1 | Transfer in progress |
| in_valid | input | 1 | Controller byte valid |
| in_byte | input | 8 | Controller byte |
| in_ready | output | 1 | Engine accepts a byte |
| out_valid | output | 1 | Byte for the controller valid |
| out_byte | output | 8 | Byte for the controller |
| out_ready | input | 1 | Controller takes the byte |
| bus_req | output | 6 | Bus request, one bit per master level |
| bg_in | input | 6 | Incoming grant chain, one bit per level |
| bg_out | output | 6 | Outgoing grant chain to the next board |
| bus_gack | output | 1 | Grant acknowledge, held while owning the bus |
| bus_strobe | output | 1 | Word cycle in progress |
| bus_we | output | 1 | Cycle writes memory |
| bus_addr | output | 23 | Word address of the cycle |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_dtack | input | 1 | Data acknowledge from memory |
| nxm_err | output | 1 | Non-existent memory flag |

## Verification
The properties assume the following about the bus side:
- bus_dtack comes only while bus_strobe is high.
- bus_dtack lasts one cycle.
- A grant on the engine's level is driven only in answer to its request.

The bench's memory responder keeps to these rules. It updates grant and acknowledge on the falling edge, and only from the request and strobe it sees there. It acknowledges only addresses inside its small decoded windows, so every other address leads to a timeout. A start pulse is sent only while the engine is idle, and an address load only while busy is low, except where the ignored-load case is exercised on purpose.

// File: rtl/dmap_pkg.sv
package dmap_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_DRAIN,
        ST_REQ,
        ST_BUS
    } dma_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } word_pair_t;

    function automatic word_pair_t put_byte(word_pair_t w, logic sel_lo,
                                            logic [BYTE_W-1:0] b);
        word_pair_t r;
        r = w;
        if (sel_lo) r.lo = b;
        else        r.hi = b;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] get_byte(word_pair_t w, logic sel_lo);
        return sel_lo ? w.lo : w.hi;
    endfunction

endpackage

// File: rtl/dmap_addr_ctr.sv
module dmap_addr_ctr #(
    parameter int AW = 23
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= load_val;
        else if (step) q <= q + AW'(1);
    end
endmodule

// File: rtl/dmap_cycle_timer.sv
module dmap_cycle_timer #(
    parameter int TMO = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TMO + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (run)   cnt <= cnt + CW'(1);
    end

    assign expired = run && (cnt == CW'(TMO - 1));
endmodule

// File: rtl/dmap_level_port.sv
module dmap_level_port #(
    parameter int NLVL = 6,
    parameter int LVL  = 3
) (
    input  logic            want,
    input  logic            own,
    input  logic [NLVL-1:0] bg_in,
    output logic [NLVL-1:0] req,
    output logic [NLVL-1:0] bg_out,
    output logic            grant_hit
);
    for (genvar i = 0; i < NLVL; i++) begin : g_lvl
        if (i == LVL) begin : g_mine
            assign req[i]    = want;
            assign bg_out[i] = bg_in[i] & ~(want | own);
        end else begin : g_other
            assign req[i]    = 1'b0;
            assign bg_out[i] = bg_in[i];
        end
    end

    assign grant_hit = want & bg_in[LVL];
endmodule

// File: rtl/dma_pack_engine.sv
module dma_pack_engine #(
    parameter int NLVL = 6,
    parameter int LVL  = 3,
    parameter int AW   = 23,
    parameter int TMO  = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            xfer_start,
    input  logic            xfer_stop,
    input  logic            dir_to_mem,
    input  logic            if_reset,
    input  logic            addr_load,
    input  logic [AW-1:0]   addr_wval,
    input  logic            inc_en,
    output logic [AW-1:0]   addr_q,
    output logic            busy,
    input  logic            in_valid,
    input  logic [7:0]      in_byte,
    output logic            in_ready,
    output logic            out_valid,
    output logic [7:0]      out_byte,
    input  logic            out_ready,
    output logic [NLVL-1:0] bus_req,
    input  logic [NLVL-1:0] bg_in,
    output logic [NLVL-1:0] bg_out,
    output logic            bus_gack,
    output logic            bus_strobe,
    output logic            bus_we,
    output logic [AW-1:0]   bus_addr,
    output logic [15:0]     bus_wdata,
    input  logic [15:0]     bus_rdata,
    input  logic            bus_dtack,
    output logic            nxm_err
);
    import dmap_pkg::*;

    dma_state_e state;
    word_pair_t wbuf;
    logic       dir_q;
    logic       half;
    logic       stop_pend;
    logic       nxm;
    logic       at_bus;
    logic       want;
    logic       grant_hit;
    logic       tmo_hit;
    logic       step;

    assign at_bus = (state == ST_BUS);
    assign want   = (state == ST_REQ);
    assign step   = at_bus && bus_dtack && inc_en;

    dmap_level_port #(.NLVL(NLVL), .LVL(LVL)) u_lvl (
        .want      (want),
        .own       (at_bus),
        .bg_in     (bg_in),
        .req       (bus_req),
        .bg_out    (bg_out),
        .grant_hit (grant_hit)
    );

    dmap_cycle_timer #(.TMO(TMO)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (!at_bus),
        .run     (at_bus && !bus_dtack),
        .expired (tmo_hit)
    );

    dmap_addr_ctr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (addr_load && state == ST_IDLE),
        .load_val (addr_wval),
        .step     (step),
        .q        (addr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            wbuf      <= '0;
            dir_q     <= 1'b0;
            half      <= 1'b0;
            stop_pend <= 1'b0;
            nxm       <= 1'b0;
        end else if (if_reset) begin
            state     <= ST_IDLE;
            half      <= 1'b0;
            stop_pend <= 1'b0;
            nxm       <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    half      <= 1'b0;
                    stop_pend <= 1'b0;
                    if (xfer_start && !nxm) begin
                        dir_q <= dir_to_mem;
                        state <= dir_to_mem ? ST_FILL : ST_REQ;
                    end
                end
                ST_FILL: begin
                    if (xfer_stop) begin
                        state <= ST_IDLE;
                    end else if (in_valid) begin
                        wbuf <= put_byte(wbuf, half, in_byte);
                        half <= ~half;
                        if (half) state <= ST_REQ;
                    end
                end
                ST_DRAIN: begin
                    if (xfer_stop) begin
                        state <= ST_IDLE;
                    end else if (out_ready) begin
                        half <= ~half;
                        if (half) state <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (xfer_stop)      state <= ST_IDLE;
                    else if (grant_hit) state <= ST_BUS;
                end
                ST_BUS: begin
                    if (xfer_stop) stop_pend <= 1'b1;
                    if (bus_dtack) begin
                        if (!dir_q) wbuf <= word_pair_t'(bus_rdata);
                        half <= 1'b0;
                        if (stop_pend || xfer_stop) state <= ST_IDLE;
                        else state <= dir_q ? ST_FILL : ST_DRAIN;
                    end else if (tmo_hit) begin
                        nxm   <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign in_ready   = (state == ST_FILL);
    assign out_valid  = (state == ST_DRAIN);
    assign out_byte   = get_byte(wbuf, half);
    assign bus_gack   = at_bus;
    assign bus_strobe = at_bus;
    assign bus_we     = dir_q;
    assign bus_addr   = addr_q;
    assign bus_wdata  = wbuf;
    assign nxm_err    = nxm;

endmodule

// File: rtl/dmap_checker.sv
module dmap_checker #(
    parameter int NLVL = 6,
    parameter int LVL  = 3,
    parameter int AW   = 23,
    parameter int TMO  = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            if_reset,
    input logic            addr_load,
    input logic            inc_en,
    input logic [AW-1:0]   addr_q,
    input logic [NLVL-1:0] bus_req,
    input logic [NLVL-1:0] bg_in,
    input logic [NLVL-1:0] bg_out,
    input logic            bus_gack,
    input logic            bus_strobe,
    input logic            bus_dtack,
    input logic            nxm_err
);
    localparam logic [NLVL-1:0] MINE = NLVL'(1) << LVL;
    localparam int RW = $clog2(TMO + 1) + 1;

    logic [RW-1:0] strobe_run;

    always_ff @(posedge clk) begin
        if (rst)             strobe_run <= '0;
        else if (bus_strobe) strobe_run <= strobe_run + RW'(1);
        else                 strobe_run <= '0;
    end

    p_req_level_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_req & ~MINE) == '0);

    p_gack_from_grant_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_gack) |-> $past(bus_req[LVL] && bg_in[LVL]));

    p_gack_release_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_gack && bus_dtack) |=> !bus_gack);

    p_daisy_block_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_req[LVL] || bus_gack) |-> !bg_out[LVL]);

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!(bus_gack && bus_dtack && inc_en) && !addr_load) |=> $stable(addr_q));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_gack && bus_dtack && inc_en) |=> addr_q == $past(addr_q) + AW'(1));

    p_tmo_bound_r8: assert property (@(posedge clk) disable iff (rst)
        strobe_run <= RW'(TMO));

    p_nxm_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(nxm_err) |-> ($past(bus_strobe) && !bus_strobe));

    p_nxm_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (nxm_err && !if_reset) |=> nxm_err);

endmodule

bind dma_pack_engine dmap_checker #(
    .NLVL(NLVL), .LVL(LVL), .AW(AW), .TMO(TMO)
) u_chk (.*);

// File: tb/test_dma_pack_engine.sv
module test_dma_pack_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 23;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xfer_start = 0, xfer_stop = 0, dir_to_mem = 0, if_reset = 0;
    logic addr_load = 0, inc_en = 0;
    logic [AW-1:0] addr_wval = '0;
    logic [AW-1:0] addr_q;
    logic busy;
    logic in_valid = 0;
    logic [7:0] in_byte = '0;
    logic in_ready, out_valid;
    logic [7:0] out_byte;
    logic out_ready = 0;
    logic [5:0] bus_req, bg_out;
    logic [5:0] bg_in = '0;
    logic bus_gack, bus_strobe, bus_we;
    logic [AW-1:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic bus_dtack = 0;
    logic nxm_err;

    int checks = 0, errors = 0;
    int lat = 0, wcnt = 0, acks = 0, we_bad = 0, gack_bad = 0;
    int run_len = 0, last_run = 0;
    bit gnt_auto = 1, exp_we = 0, done = 0;
    logic [15:0] mem [128];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_pack_engine i_dma_pack_engine (.*);

    function automatic logic [6:0] midx(logic [AW-1:0] a);
        return {a[AW-1], a[5:0]};
    endfunction

    function automatic bit decoded(logic [AW-1:0] a);
        return (a < 64) || (a >= 23'h7FFFC0);
    endfunction

    function automatic logic [7:0] wpat(int s, int k, int j);
        return 8'(s * 29 + k * 37 + j * 11 + 5);
    endfunction

    function automatic logic [15:0] rdpat(logic [AW-1:0] a);
        return 16'(a * 16'h0305) ^ 16'hA55A;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory and arbiter model, updated away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (gnt_auto) bg_in = {2'b00, bus_req[3], 3'b000};
            if (bus_strobe) begin
                run_len++;
                if (bus_we != exp_we) we_bad++;
                if (!bus_gack) gack_bad++;
            end else begin
                if (run_len != 0) last_run = run_len;
                run_len = 0;
            end
            if (bus_strobe && !bus_dtack) begin
                if (decoded(bus_addr)) begin
                    if (wcnt >= lat) begin
                        bus_dtack = 1'b1;
                        acks++;
                        wcnt = 0;
                        if (bus_we) mem[midx(bus_addr)] = bus_wdata;
                        else bus_rdata = mem[midx(bus_addr)];
                    end else wcnt++;
                end
            end else begin
                bus_dtack = 1'b0;
                wcnt = 0;
            end
        end
    end

    task automatic load_addr(input logic [AW-1:0] v);
        addr_wval = v; addr_load = 1'b1;
        @(negedge clk);
        addr_load = 1'b0;
    endtask

    task automatic start(input bit d);
        dir_to_mem = d; exp_we = d; xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic stop_pulse();
        xfer_stop = 1'b1;
        @(negedge clk);
        xfer_stop = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        in_byte = b; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pull(output logic [7:0] b);
        out_ready = 1'b1;
        while (!out_valid) @(negedge clk);
        b = out_byte;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic wait_fill();
        while (!in_ready) @(negedge clk);
    endtask

    task automatic run_xfer(input bit d, input int lat_i, input bit inc_i,
                            input int base, input int nw, input int s);
        int a0;
        logic [7:0] b;
        logic [15:0] w;
        lat = lat_i; inc_en = inc_i; we_bad = 0; gack_bad = 0;
        load_addr(AW'(base));
        a0 = acks;
        if (d) begin
            start(1'b1);
            for (int k = 0; k < nw; k++) begin
                push(wpat(s, k, 0));
                push(wpat(s, k, 1));
                wait_fill();
            end
            stop_pulse();
            for (int k = 0; k < (inc_i ? nw : 1); k++) begin
                int kk;
                kk = inc_i ? k : nw - 1;
                w = mem[midx(AW'(base + k))];
                check(w == {wpat(s, kk, 0), wpat(s, kk, 1)}, "R1 packed word",
                      w, {wpat(s, kk, 0), wpat(s, kk, 1)});
            end
        end else begin
            for (int k = 0; k < nw; k++)
                mem[midx(AW'(base + k))] = rdpat(AW'(base + k));
            start(1'b0);
            for (int k = 0; k < nw; k++) begin
                w = rdpat(AW'(inc_i ? base + k : base));
                pull(b);
                check(b == w[15:8], "R2 high byte first", b, w[15:8]);
                pull(b);
                check(b == w[7:0], "R2 low byte second", b, w[7:0]);
            end
            stop_pulse();
        end
        check(acks - a0 == nw, "R1 one bus cycle per byte pair", acks - a0, nw);
        check(addr_q == AW'(base + (inc_i ? nw : 0)), "R4 address after transfer",
              addr_q, base + (inc_i ? nw : 0));
        check(we_bad == 0, "R10 direction on bus_we", we_bad, 0);
        check(gack_bad == 0, "R6 gack held during strobe", gack_bad, 0);
        check(busy == 1'b0, "R11 idle after stop", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        for (int i = 0; i < 128; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check(busy == 0 && bus_req == 0 && bus_gack == 0, "R6 reset outputs idle",
              {busy, bus_req, bus_gack}, 0);
        check(addr_q == 0 && nxm_err == 0, "R3 reset address and flag",
              {nxm_err, addr_q}, 0);

        // R3 load and readback
        load_addr(23'h000015);
        check(addr_q == 23'h15 && bus_addr == 23'h15, "R3 load readback", addr_q, 23'h15);

        // sweep: direction x increment x latency
        for (int lt = 0; lt < 3; lt++)
            for (int ic = 0; ic < 2; ic++)
                for (int dr = 0; dr < 2; dr++)
                    run_xfer(dr[0], lt, ic[0], 2 + lt * 20 + ic * 10, 3, lt * 4 + ic * 2 + dr);

        // R4 wrap at the top of the address range
        run_xfer(1'b1, 1, 1'b1, 23'h7FFFFE, 3, 9);
        check(mem[midx(23'h000000)] == {wpat(9, 2, 0), wpat(9, 2, 1)}, "R4 wrapped word",
              mem[midx(23'h000000)], {wpat(9, 2, 0), wpat(9, 2, 1)});

        // R7 / R5 / R6 daisy chain and grant handling
        gnt_auto = 0; lat = 0; inc_en = 1'b0;
        load_addr(23'd40);
        bg_in = 6'b001000; #1;
        check(bg_out == 6'b001000, "R7 grant passed when idle", bg_out, 6'b001000);
        bg_in = 6'b000010; #1;
        check(bg_out == 6'b000010, "R7 other level passes", bg_out, 6'b000010);
        bg_in = 6'b000000;
        start(1'b1);
        push(8'h3C);
        check(addr_q == 23'd40, "R3 load ignored while busy (before)", addr_q, 23'd40);
        load_addr(23'd7);
        check(addr_q == 23'd40, "R3 load ignored while busy", addr_q, 23'd40);
        push(8'hC3);
        check(bus_req == 6'b001000, "R5 request on level 3 only", bus_req, 6'b001000);
        check(bus_gack == 0, "R5 no cycle before grant", bus_gack, 0);
        bg_in = 6'b001010; #1;
        check(bg_out == 6'b000010, "R7 grant blocked while requesting", bg_out, 6'b000010);
        @(negedge clk);
        bg_in = 6'b000000; gnt_auto = 1;
        check(bus_gack == 1 && bus_strobe == 1, "R6 gack after accepted grant",
              {bus_gack, bus_strobe}, 2'b11);
        wait_fill();
        check(bus_gack == 0 && mem[midx(23'd40)] == 16'h3CC3, "R6 released after dtack",
              {bus_gack, mem[midx(23'd40)]}, 16'h3CC3);
        stop_pulse();

        // R11 partial pair discarded
        start(1'b1);
        push(8'hAA);
        stop_pulse();
        check(busy == 0 && bus_req == 0, "R11 stop drops half pair", {busy, bus_req}, 0);
        start(1'b1);
        push(8'h11);
        push(8'h22);
        wait_fill();
        check(mem[midx(23'd40)] == 16'h1122, "R11 fresh pair after stop",
              mem[midx(23'd40)], 16'h1122);
        stop_pulse();

        // R11 stop during a bus cycle lets it finish
        lat = 6;
        start(1'b1);
        push(8'h5E);
        push(8'hE5);
        while (!bus_strobe) @(negedge clk);
        stop_pulse();
        while (bus_strobe) @(negedge clk);
        check(busy == 0 && mem[midx(23'd40)] == 16'h5EE5, "R11 cycle completes then idle",
              {busy, mem[midx(23'd40)]}, 16'h5EE5);

        // R8 timeout on undecoded address
        lat = 0;
        load_addr(23'd100);
        start(1'b1);
        push(8'h01);
        push(8'h02);
        while (busy) @(negedge clk);
        @(negedge clk);
        check(last_run == 64, "R8 strobe length at timeout", last_run, 64);
        check(nxm_err == 1 && bus_gack == 0, "R8 flag set and bus released",
              {nxm_err, bus_gack}, 2'b10);
        check(addr_q == 23'd100, "R8 no increment on timeout", addr_q, 23'd100);

        // R9 sticky flag, start blocked, interface reset clears
        start(1'b1);
        @(negedge clk);
        check(busy == 0 && nxm_err == 1, "R9 start ignored while flagged",
              {busy, nxm_err}, 2'b01);
        if_reset = 1'b1;
        @(negedge clk);
        if_reset = 1'b0;
        check(nxm_err == 0, "R9 interface reset clears flag", nxm_err, 0);
        start(1'b0);
        check(busy == 1, "R10 start accepted after clear", busy, 1);
        stop_pulse();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule